// File: doc/BRIEF.md
# Lookup-Table DAC Code Selector

This block chooses the 8-bit code and the polarity for each of two current-output DACs. A DAC channel can run in one of three modes:
- **Direct:** a control byte is forwarded as the code.
- **Manual row:** a fixed row of that channel's lookup table is read.
- **Conversion-indexed:** the table row follows the most recent analog-to-digital conversion. In a sensing application this lets the output current follow the measured temperature or voltage.

Each channel also carries a sink/source flag and a two-bit full-scale range field, and both are registered alongside the code. The ADC result arrives as a digital input together with a conversion-valid strobe. A bit that selects which analog input the converter samples is registered and passed out. Both tables, one per channel with 64 rows each, are loaded through a synchronous byte-write port.

Every output is registered. A change in mode, direct byte, polarity or range appears on the outputs at the clock edge that samples it. In conversion-indexed mode the row index moves only when a conversion completes, so the code changes at most once per conversion.

Top module: `lutdac_code_sel`

## Requirements
- R1: While reset is asserted, every DAC code is 0, every direction flag is 0 (source), every range field is 0 and the sense-select output is 0.
- R2: When a channel's direct-enable bit is 1, that channel's code at the next clock edge equals its direct byte, whatever its row-override bit holds.
- R3: When direct-enable and row-override are both 0 and at least one conversion has been accepted, the code equals the channel's table entry at row adcResult[7:2], captured at the last edge where adcValid was 1. The code reflects a newly captured row one edge after the capture edge.
- R4: A change of adcResult while adcValid is 0 leaves the codes of conversion-indexed channels unchanged.
- R5: In conversion-indexed mode the code is 0 until the first edge at which adcValid is 1 has passed.
- R6: When direct-enable is 0 and row-override is 1, the code equals the channel's table entry at the row given by that channel's manualRow field.
- R7: A write with lutWrEn=1 stores lutWrData in the table selected by lutWrAddr[6] (0 for channel 0, 1 for channel 1), at the row lutWrAddr[5:0]. It leaves the other table unchanged. A code that reads the written row shows the new byte from the edge after the write edge.
- R8: dacSink[c] equals sinkSel[c] one edge after it is sampled: 1 means sink, 0 means source.
- R9: dacRange for each channel equals that channel's rangeSel field one edge after it is sampled, bit for bit.
- R10: senseSelOut equals senseSelIn one edge after it is sampled: 0 selects the external sense pin and 1 selects the on-chip temperature sensor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| adcResult | input | 8 | Latest conversion result |
| adcValid | input | 1 | Conversion-complete strobe, captures the row index |
| senseSelIn | input | 1 | ADC input choice: 0 external pin, 1 temperature sensor |
| senseSelOut | output | 1 | Registered ADC input choice |
| directEn | input | 2 | Per-channel direct-byte enable |
| rowOvr | input | 2 | Per-channel manual-row enable |
| directByte | input | 16 | Direct codes, channel c at [8c+7:8c] |
| manualRow | input | 12 | Manual rows, channel c at [6c+5:6c] |
| sinkSel | input | 2 | Per-channel polarity, 1 sink |
| rangeSel | input | 4 | Full-scale range, channel c at [2c+1:2c] |
| lutWrEn | input | 1 | Table write enable |
| lutWrAddr | input | 7 | Bit 6 table, bits 5:0 row |
| lutWrData | input | 8 | Table write byte |
| dacCode | output | 16 | DAC codes, channel c at [8c+7:8c] |
| dacSink | output | 2 | Registered polarity flags |
| dacRange | output | 4 | Registered range fields |

## Verification
The bench fills both tables and then goes after five corner cases.
- **Zero before the first conversion:** the window before any conversion arrives, where a design that read the table early would show a stale row instead of zero.
- **Direct priority:** direct-enable and row-override set together, where a wrong priority shows a table byte in place of the direct byte.
- **Row capture timing:** adcResult moving without a strobe, where a design that indexes straight from the input would drift with noise. The one-edge delay after a strobe is also checked, where an extra or missing register shifts the code by a cycle.
- **Table isolation:** writes to one table while both channels read the same row, where a bad decode of the table-select bit corrupts the neighbour channel.
- **Write-then-read timing:** a read of a row the edge after it is written, where a read path with the wrong ordering returns the old byte.

// File: rtl/lutdac_pkg.sv
package lutdac_pkg;

  // Source selected for one DAC channel
  typedef enum logic [1:0] {
    SRC_ADC    = 2'd0,
    SRC_ROW    = 2'd1,
    SRC_DIRECT = 2'd2
  } srcMode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic rowLoad;   // capture a new row index from the ADC result
    logic convSeen;  // at least one conversion accepted since reset
    logic lutWrite;  // table write in this cycle
  } ctrlStrobe_t;

endpackage

// File: rtl/lutdac_ctrl.sv
module lutdac_ctrl
  import lutdac_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 7,
  parameter int TSEL_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              adcValid,
  input  logic              senseSelIn,
  input  logic [NUM_CH-1:0] directEn,
  input  logic [NUM_CH-1:0] rowOvr,
  input  logic              lutWrEn,
  input  logic [ADDR_W-1:0] lutWrAddr,
  output ctrlStrobe_t       strobe,
  output srcMode_t          chMode [NUM_CH],
  output logic [NUM_CH-1:0] tblWrSel,
  output logic              senseSelOut
);

  logic convSeenQ;
  logic senseQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convSeenQ <= 1'b0;
      senseQ    <= 1'b0;
    end else begin
      if (adcValid) convSeenQ <= 1'b1;
      senseQ <= senseSelIn;
    end
  end

  always_comb begin
    strobe.rowLoad  = adcValid;
    strobe.convSeen = convSeenQ;
    strobe.lutWrite = lutWrEn;
  end

  assign senseSelOut = senseQ;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_mode
    // direct byte wins over the manual row
    always_comb begin
      if (directEn[ch])    chMode[ch] = SRC_DIRECT;
      else if (rowOvr[ch]) chMode[ch] = SRC_ROW;
      else                 chMode[ch] = SRC_ADC;
    end
    // table select lives in the top address bits
    assign tblWrSel[ch] = lutWrEn &&
      (lutWrAddr[ADDR_W-1 -: TSEL_W] == TSEL_W'(ch));
  end

  // R5: once a conversion is seen the flag never drops before reset
  a_r5_seen_sticky: assert property (@(posedge clk) disable iff (!rstN)
    convSeenQ |=> convSeenQ);

  // R5: the flag rises only after a strobe
  a_r5_seen_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convSeenQ) |-> $past(adcValid));

  // R7: a write hits at most one table
  a_r7_one_table: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tblWrSel));

  // R10: sense choice follows its input by one edge
  a_r10_sense_follow: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (senseSelOut == $past(senseSelIn)));

endmodule

// File: rtl/lutdac_datapath.sv
module lutdac_datapath
  import lutdac_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int CODE_W  = 8,
  parameter int ADC_W   = 8,
  parameter int ROW_W   = 6,
  parameter int RANGE_W = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobe_t               strobe,
  input  srcMode_t                  chMode [NUM_CH],
  input  logic [NUM_CH-1:0]         tblWrSel,
  input  logic [ROW_W-1:0]          wrRow,
  input  logic [CODE_W-1:0]         wrData,
  input  logic [ADC_W-1:0]          adcResult,
  input  logic [NUM_CH*CODE_W-1:0]  directByte,
  input  logic [NUM_CH*ROW_W-1:0]   manualRow,
  input  logic [NUM_CH-1:0]         sinkSel,
  input  logic [NUM_CH*RANGE_W-1:0] rangeSel,
  output logic [NUM_CH*CODE_W-1:0]  dacCode,
  output logic [NUM_CH-1:0]         dacSink,
  output logic [NUM_CH*RANGE_W-1:0] dacRange
);

  localparam int LUT_DEPTH = 1 << ROW_W;

  logic [ROW_W-1:0] adcRowQ;

  // row index taken from the top bits of the conversion result
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               adcRowQ <= '0;
    else if (strobe.rowLoad) adcRowQ <= adcResult[ADC_W-1 -: ROW_W];
  end

  // R4: the index moves only on a conversion strobe
  a_r4_row_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rowLoad |=> $stable(adcRowQ));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [CODE_W-1:0]  tbl [LUT_DEPTH];
    logic [ROW_W-1:0]   rowSel;
    logic [CODE_W-1:0]  tblData;
    logic [CODE_W-1:0]  codeNxt;
    logic [CODE_W-1:0]  codeQ;
    logic               sinkQ;
    logic [RANGE_W-1:0] rangeQ;

    always_ff @(posedge clk) begin
      if (strobe.lutWrite && tblWrSel[ch]) tbl[wrRow] <= wrData;
    end

    assign rowSel  = (chMode[ch] == SRC_ROW) ? manualRow[ch*ROW_W +: ROW_W]
                                             : adcRowQ;
    assign tblData = tbl[rowSel];

    always_comb begin
      unique case (chMode[ch])
        SRC_DIRECT: codeNxt = directByte[ch*CODE_W +: CODE_W];
        SRC_ROW:    codeNxt = tblData;
        default:    codeNxt = strobe.convSeen ? tblData : '0;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        codeQ  <= '0;
        sinkQ  <= 1'b0;
        rangeQ <= '0;
      end else begin
        codeQ  <= codeNxt;
        sinkQ  <= sinkSel[ch];
        rangeQ <= rangeSel[ch*RANGE_W +: RANGE_W];
      end
    end

    assign dacCode[ch*CODE_W +: CODE_W]    = codeQ;
    assign dacSink[ch]                     = sinkQ;
    assign dacRange[ch*RANGE_W +: RANGE_W] = rangeQ;

    // R2: direct byte appears at the next edge
    a_r2_direct_next: assert property (@(posedge clk) disable iff (!rstN)
      (chMode[ch] == SRC_DIRECT) |=>
        (dacCode[ch*CODE_W +: CODE_W] == $past(directByte[ch*CODE_W +: CODE_W])));

    // R5: conversion-indexed code stays zero before any conversion
    a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
      ((chMode[ch] == SRC_ADC) && !strobe.convSeen) |=>
        (dacCode[ch*CODE_W +: CODE_W] == '0));

    // R8: polarity follows its control bit by one edge
    a_r8_polarity: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> (dacSink[ch] == $past(sinkSel[ch])));

    // R9: range field passes through unchanged
    a_r9_range: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> (dacRange[ch*RANGE_W +: RANGE_W] ==
                $past(rangeSel[ch*RANGE_W +: RANGE_W])));
  end

endmodule

// File: rtl/lutdac_code_sel.sv
module lutdac_code_sel
  import lutdac_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int CODE_W  = 8,
  parameter int ADC_W   = 8,
  parameter int ROW_W   = 6,
  parameter int RANGE_W = 2,
  localparam int TSEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = ROW_W + TSEL_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [ADC_W-1:0]          adcResult,
  input  logic                      adcValid,
  input  logic                      senseSelIn,
  output logic                      senseSelOut,
  input  logic [NUM_CH-1:0]         directEn,
  input  logic [NUM_CH-1:0]         rowOvr,
  input  logic [NUM_CH*CODE_W-1:0]  directByte,
  input  logic [NUM_CH*ROW_W-1:0]   manualRow,
  input  logic [NUM_CH-1:0]         sinkSel,
  input  logic [NUM_CH*RANGE_W-1:0] rangeSel,
  input  logic                      lutWrEn,
  input  logic [ADDR_W-1:0]         lutWrAddr,
  input  logic [CODE_W-1:0]         lutWrData,
  output logic [NUM_CH*CODE_W-1:0]  dacCode,
  output logic [NUM_CH-1:0]         dacSink,
  output logic [NUM_CH*RANGE_W-1:0] dacRange
);

  ctrlStrobe_t       strobe;
  srcMode_t          chMode [NUM_CH];
  logic [NUM_CH-1:0] tblWrSel;

  lutdac_ctrl #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .TSEL_W (TSEL_W)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .adcValid    (adcValid),
    .senseSelIn  (senseSelIn),
    .directEn    (directEn),
    .rowOvr      (rowOvr),
    .lutWrEn     (lutWrEn),
    .lutWrAddr   (lutWrAddr),
    .strobe      (strobe),
    .chMode      (chMode),
    .tblWrSel    (tblWrSel),
    .senseSelOut (senseSelOut)
  );

  lutdac_datapath #(
    .NUM_CH  (NUM_CH),
    .CODE_W  (CODE_W),
    .ADC_W   (ADC_W),
    .ROW_W   (ROW_W),
    .RANGE_W (RANGE_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .chMode     (chMode),
    .tblWrSel   (tblWrSel),
    .wrRow      (lutWrAddr[ROW_W-1:0]),
    .wrData     (lutWrData),
    .adcResult  (adcResult),
    .directByte (directByte),
    .manualRow  (manualRow),
    .sinkSel    (sinkSel),
    .rangeSel   (rangeSel),
    .dacCode    (dacCode),
    .dacSink    (dacSink),
    .dacRange   (dacRange)
  );

endmodule

// File: tb/lutdac_code_sel_tb_top.sv
`timescale 1ns/1ps
module lutdac_code_sel_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  adcResult;
  logic        adcValid;
  logic        senseSelIn;
  logic        senseSelOut;
  logic [1:0]  directEn;
  logic [1:0]  rowOvr;
  logic [15:0] directByte;
  logic [11:0] manualRow;
  logic [1:0]  sinkSel;
  logic [3:0]  rangeSel;
  logic        lutWrEn;
  logic [6:0]  lutWrAddr;
  logic [7:0]  lutWrData;
  logic [15:0] dacCode;
  logic [1:0]  dacSink;
  logic [3:0]  dacRange;

  always #10 clk = ~clk;  // 50 MHz

  lutdac_code_sel dut_i (
    .clk(clk), .rstN(rstN), .adcResult(adcResult), .adcValid(adcValid),
    .senseSelIn(senseSelIn), .senseSelOut(senseSelOut),
    .directEn(directEn), .rowOvr(rowOvr), .directByte(directByte),
    .manualRow(manualRow), .sinkSel(sinkSel), .rangeSel(rangeSel),
    .lutWrEn(lutWrEn), .lutWrAddr(lutWrAddr), .lutWrData(lutWrData),
    .dacCode(dacCode), .dacSink(dacSink), .dacRange(dacRange)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit modelOn = 0;
  string phaseTag = "";

  // behavioural reference state
  int lutM [2][64];
  int rowIdx = 0;
  bit seen = 0;
  int expCode [2];
  int expSink [2];
  int expRange [2];
  int expSense = 0;
  string expTag [2];
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed[30:15]);
  endfunction

  // model: evaluate with pre-edge state, then update state
  always @(posedge clk) begin
    if (!rstN) begin
      seen = 0; rowIdx = 0; expSense = 0;
      for (int c = 0; c < 2; c++) begin
        expCode[c] = 0; expSink[c] = 0; expRange[c] = 0; expTag[c] = "R1";
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (directEn[c]) begin
          expCode[c] = directByte[c*8 +: 8]; expTag[c] = "R2";
        end else if (rowOvr[c]) begin
          expCode[c] = lutM[c][manualRow[c*6 +: 6]]; expTag[c] = "R6";
        end else if (seen) begin
          expCode[c] = lutM[c][rowIdx]; expTag[c] = "R3";
        end else begin
          expCode[c] = 0; expTag[c] = "R5";
        end
        expSink[c]  = sinkSel[c];
        expRange[c] = rangeSel[c*2 +: 2];
      end
      expSense = senseSelIn;
      if (lutWrEn) lutM[lutWrAddr[6]][lutWrAddr[5:0]] = lutWrData;
      if (adcValid) begin
        rowIdx = adcResult[7:2];
        seen = 1;
      end
    end
    modelOn = 1;
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (modelOn && !finished) begin
      for (int c = 0; c < 2; c++) begin
        chk((phaseTag != "") ? phaseTag : expTag[c], dacCode[c*8 +: 8], expCode[c]);
        chk("R8", dacSink[c], expSink[c]);
        chk("R9", dacRange[c*2 +: 2], expRange[c]);
      end
      chk("R10", senseSelOut, expSense);
    end
  end

  task automatic tick();
    @(posedge clk); #5;
  endtask

  task automatic randomInputs(bit allowWrite);
    adcValid   = (rnd() % 4) == 0;
    adcResult  = 8'(rnd());
    senseSelIn = rnd() % 2;
    for (int c = 0; c < 2; c++) begin
      directEn[c] = (rnd() % 4) == 0;
      rowOvr[c]   = (rnd() % 3) == 0;
      sinkSel[c]  = rnd() % 2;
      rangeSel[c*2 +: 2]   = 2'(rnd());
      directByte[c*8 +: 8] = 8'(rnd());
      manualRow[c*6 +: 6]  = 6'(rnd());
    end
    lutWrEn   = allowWrite && ((rnd() % 8) == 0);
    lutWrAddr = 7'(rnd());
    lutWrData = 8'(rnd());
  endtask

  initial begin
    rstN = 0; adcResult = 0; adcValid = 0; senseSelIn = 0;
    directEn = 0; rowOvr = 0; directByte = 0; manualRow = 0;
    sinkSel = 0; rangeSel = 0; lutWrEn = 0; lutWrAddr = 0; lutWrData = 0;
    for (int c = 0; c < 2; c++) for (int r = 0; r < 64; r++) lutM[c][r] = 0;
    // R1: reset outputs checked by the per-clock compare while held in reset
    repeat (3) @(posedge clk);
    // drive non-zero controls during reset: outputs must still read zero (R1)
    #5; sinkSel = 2'b11; rangeSel = 4'hF; senseSelIn = 1; directEn = 2'b11;
    directByte = 16'hFFFF;
    @(negedge clk);
    chk("R1", dacCode, 0); chk("R1", dacSink, 0);
    chk("R1", dacRange, 0); chk("R1", senseSelOut, 0);
    #5; rstN = 1; directEn = 0; sinkSel = 0; rangeSel = 0; senseSelIn = 0;

    // fill both tables (R7 write path), ADC mode with no conversion yet
    for (int a = 0; a < 128; a++) begin
      lutWrEn = 1; lutWrAddr = 7'(a); lutWrData = 8'((a * 37 + 11) & 255);
      tick();
    end
    lutWrEn = 0;

    // R5: conversion-indexed mode before any conversion must read zero
    phaseTag = "R5";
    for (int i = 0; i < 6; i++) begin
      adcResult = 8'(rnd()); sinkSel = 2'(i); rangeSel = 4'(i * 3);
      tick();
    end
    phaseTag = "";

    // R2 priority: both select bits set, direct byte must win
    directEn = 2'b11; rowOvr = 2'b11; directByte = 16'hA55A; manualRow = 12'h041;
    tick(); tick();
    chk("R2", dacCode, 16'hA55A);

    // mixed random traffic (R2, R3, R6, R8, R9, R10 via the model)
    for (int i = 0; i < 600; i++) begin
      randomInputs(1'b1);
      tick();
    end

    // R3/R4: capture one row, then move adcResult without a strobe
    lutWrEn = 0; directEn = 0; rowOvr = 0;
    adcValid = 1; adcResult = 8'hA4;  // row 41
    tick();
    adcValid = 0;
    tick(); tick();
    chk("R3", dacCode[7:0], lutM[0][41]);
    chk("R3", dacCode[15:8], lutM[1][41]);
    phaseTag = "R4";
    for (int i = 0; i < 5; i++) begin
      adcResult = 8'(rnd());
      tick();
    end
    @(negedge clk);
    chk("R4", dacCode[7:0], lutM[0][41]);
    chk("R4", dacCode[15:8], lutM[1][41]);
    #5;

    // R7: both channels read row 5; write table 1 then table 0
    phaseTag = "R7";
    rowOvr = 2'b11; manualRow = {6'd5, 6'd5};
    tick();
    lutWrEn = 1; lutWrAddr = {1'b1, 6'd5}; lutWrData = 8'h5A;
    tick();
    lutWrEn = 0;
    tick();
    chk("R7", dacCode[15:8], 8'h5A);
    chk("R7", dacCode[7:0], lutM[0][5]);
    lutWrEn = 1; lutWrAddr = {1'b0, 6'd5}; lutWrData = 8'hC3;
    tick();
    lutWrEn = 0;
    tick();
    chk("R7", dacCode[7:0], 8'hC3);
    chk("R7", dacCode[15:8], 8'h5A);
    phaseTag = "";
    tick(); tick();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule